// File: doc/BRIEF.md
# Systolic Array Processing Cell

This block is one compute element of a coarse-grained reconfigurable array. A configuration strobe captures an operation code and, when wanted, a constant coefficient. After that the cell repeats the captured operation on every clock cycle and does not fetch or decode anything per cycle. This continues until a new configuration arrives or the enable input drops.

Each cycle the cell takes three inputs: a signed data operand, a second operand, and the registered result of the neighbouring cell upstream. The second operand comes either from a port or from the latched constant, depending on a configuration bit. The cell computes one result in one cycle and places it in its own output register. That register feeds the next cell in the chain, so cells placed end to end form a systolic pipeline such as a tapped filter.

Top module: `sa_cell`

## Requirements
- R1: A synchronous reset clears the result register to zero and sets the latched operation to no-operation. A code that is not in the table below also acts as no-operation.
- R2: Operation codes on `cfg_op` (3 bits) are 0 = hold (no-operation), 1 = add, 2 = subtract, 3 = multiply-accumulate, 4 = multiply-subtract. Codes 5 to 7 behave as hold.
- R3: Add stores `a + b` and subtract stores `a - b` in the result register one cycle after the operands are presented.
- R4: Multiply-accumulate stores `chain_in + a*b`. Multiply-subtract stores `chain_in - a*b`. The accumulate term is the upstream neighbour's output.
- R5: Operands are 16-bit two's complement and the result is 32-bit two's complement. Arithmetic wraps modulo 2^32 with no saturation.
- R6: When `cfg_use_const` is 1 at load, the second operand is the 16-bit constant captured from `cfg_coef`, and the `b` port has no effect on the result. When it is 0, `b` is used.
- R7: A configuration loaded on the edge where `cfg_load` is high governs the result computed on the next edge. The load itself does not change the result register on that edge.
- R8: While `en` is 0 the result register keeps its value, and the latched configuration still accepts loads.
- R9: Under hold (no-operation) with `en` high, the result register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Cell enable; low freezes the result |
| cfg_load | input | 1 | Configuration strobe |
| cfg_op | input | 3 | Operation code to latch |
| cfg_use_const | input | 1 | Select latched constant as second operand |
| cfg_coef | input | 16 | Constant coefficient to latch |
| a | input | 16 | Data operand |
| b | input | 16 | Second operand from the fabric |
| chain_in | input | 32 | Result register of upstream cell |
| res | output | 32 | Result register, drives downstream cell |

## Verification
A wrong latched operation code or constant shows up at `res` on the first enabled edge after the load, as a value that differs from the expected arithmetic. A stuck or leaking enable, or a result register disturbed by a load, shows as a changed `res` one cycle after the stimulus, when the value should have been held. Because every cell computes one result per cycle, any internal corruption reaches the output within one clock. The bench therefore compares `res` after every edge.

// File: rtl/sa_cell_pkg.sv
package sa_cell_pkg;
   typedef enum logic [2:0] {
      OP_HOLD = 3'd0,
      OP_ADD  = 3'd1,
      OP_SUB  = 3'd2,
      OP_MAC  = 3'd3,
      OP_MSB  = 3'd4
   } cell_op_e;

   function automatic cell_op_e decode_op(input logic [2:0] code);
      case (code)
         3'd1: return OP_ADD;
         3'd2: return OP_SUB;
         3'd3: return OP_MAC;
         3'd4: return OP_MSB;
         default: return OP_HOLD;
      endcase
   endfunction
endpackage

// File: rtl/sa_cell_cfg.sv
module sa_cell_cfg
   import sa_cell_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [2:0]    op_in,
   input  logic          use_const_in,
   input  logic [DW-1:0] coef_in,
   output cell_op_e      op_q,
   output logic          use_const_q,
   output logic [DW-1:0] coef_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         op_q        <= OP_HOLD;
         use_const_q <= 1'b0;
         coef_q      <= '0;
      end else if (load) begin
         op_q        <= decode_op(op_in);
         use_const_q <= use_const_in;
         coef_q      <= coef_in;
      end
   end
endmodule

// File: rtl/sa_cell_alu.sv
module sa_cell_alu
   import sa_cell_pkg::*;
#(
   parameter int DW = 16,
   parameter int RW = 32
) (
   input  cell_op_e              op,
   input  logic signed [DW-1:0]  opa,
   input  logic signed [DW-1:0]  opb,
   input  logic signed [RW-1:0]  acc,
   input  logic signed [RW-1:0]  cur,
   output logic signed [RW-1:0]  nxt
);
   localparam int PW = 2 * DW;
   logic signed [PW-1:0] prod;
   logic signed [RW-1:0] prod_x, a_x, b_x;

   assign prod = opa * opb;

   generate
      if (RW >= PW) begin : g_wide
         assign prod_x = RW'(prod);
      end else begin : g_narrow
         assign prod_x = prod[RW-1:0];
      end
   endgenerate

   assign a_x = RW'(opa);
   assign b_x = RW'(opb);

   always_comb begin
      case (op)
         OP_ADD:  nxt = a_x + b_x;
         OP_SUB:  nxt = a_x - b_x;
         OP_MAC:  nxt = acc + prod_x;
         OP_MSB:  nxt = acc - prod_x;
         default: nxt = cur;
      endcase
   end
endmodule

// File: rtl/sa_cell.sv
module sa_cell
   import sa_cell_pkg::*;
#(
   parameter int DW = 16,
   parameter int RW = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic                 cfg_load,
   input  logic [2:0]           cfg_op,
   input  logic                 cfg_use_const,
   input  logic [DW-1:0]        cfg_coef,
   input  logic signed [DW-1:0] a,
   input  logic signed [DW-1:0] b,
   input  logic signed [RW-1:0] chain_in,
   output logic signed [RW-1:0] res
);
   initial begin
      if (DW < 2) $error("sa_cell: DW too small");
      if (RW <= DW) $error("sa_cell: RW must exceed DW");
   end

   cell_op_e             op_q;
   logic                 use_const_q;
   logic [DW-1:0]        coef_q;
   logic signed [DW-1:0] opb_sel;
   logic signed [RW-1:0] nxt;

   sa_cell_cfg #(.DW(DW)) u_cfg (
      .clk(clk), .rst(rst), .load(cfg_load),
      .op_in(cfg_op), .use_const_in(cfg_use_const), .coef_in(cfg_coef),
      .op_q(op_q), .use_const_q(use_const_q), .coef_q(coef_q)
   );

   assign opb_sel = use_const_q ? $signed(coef_q) : b;

   sa_cell_alu #(.DW(DW), .RW(RW)) u_alu (
      .op(op_q), .opa(a), .opb(opb_sel), .acc(chain_in), .cur(res), .nxt(nxt)
   );

   always_ff @(posedge clk) begin
      if (rst)     res <= '0;
      else if (en) res <= nxt;
   end
endmodule

// File: rtl/sa_cell_chk.sv
module sa_cell_chk #(
   parameter int RW = 32
) (
   input logic          clk,
   input logic          rst,
   input logic          en,
   input logic          cfg_load,
   input logic [2:0]    cfg_op,
   input logic [RW-1:0] res
);
   logic live;
   always_ff @(posedge clk) live <= 1'b1;

   // R1
   property reset_clear_p;
      @(posedge clk) rst |=> (res == '0);
   endproperty
   reset_clear_chk: assert property (reset_clear_p);

   // R8
   property hold_disabled_p;
      @(posedge clk) disable iff (rst) (live && !en) |=> $stable(res);
   endproperty
   hold_disabled_chk: assert property (hold_disabled_p);

   // R2
   property bad_code_hold_p;
      @(posedge clk) disable iff (rst) (cfg_load && cfg_op > 3'd4) |=> ##1 $stable(res);
   endproperty
   bad_code_hold_chk: assert property (bad_code_hold_p);

   // R9
   property nop_hold_p;
      @(posedge clk) disable iff (rst) (cfg_load && cfg_op == 3'd0) |=> ##1 $stable(res);
   endproperty
   nop_hold_chk: assert property (nop_hold_p);

   // R7
   property load_no_disturb_p;
      @(posedge clk) disable iff (rst) (live && cfg_load && !en) |=> $stable(res);
   endproperty
   load_no_disturb_chk: assert property (load_no_disturb_p);

   // R1
   always_comb begin
      if (live && !rst) res_known_chk: assert (!$isunknown(res));
   end
endmodule

bind sa_cell sa_cell_chk #(.RW(RW)) u_chk (
   .clk(clk), .rst(rst), .en(en), .cfg_load(cfg_load), .cfg_op(cfg_op), .res(res)
);

// File: tb/sa_cell_test.sv
module sa_cell_test;
   logic clk = 1'b0;
   logic rst, en, cfg_load, cfg_use_const;
   logic [2:0] cfg_op;
   logic [15:0] cfg_coef;
   logic signed [15:0] a, b;
   logic signed [31:0] chain_in;
   logic signed [31:0] res;
   int checks = 0, fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   sa_cell uut (.clk, .rst, .en, .cfg_load, .cfg_op, .cfg_use_const,
                .cfg_coef, .a, .b, .chain_in, .res);

   task automatic chk(input string req, input logic signed [31:0] exp);
      checks++;
      if (res !== exp) begin
         fails++;
         $display("FAIL %s got=%0d exp=%0d", req, res, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk); #1;
   endtask

   task automatic load(input logic [2:0] op, input logic uc, input logic [15:0] k);
      cfg_load = 1; cfg_op = op; cfg_use_const = uc; cfg_coef = k;
      tick();
      cfg_load = 0;
   endtask

   function automatic logic signed [31:0] model(input int op, input logic signed [15:0] x,
         input logic signed [15:0] y, input logic signed [31:0] c, input logic signed [31:0] prev);
      logic signed [31:0] p;
      p = 32'(x) * 32'(y);
      case (op)
         1: return 32'(x) + 32'(y);
         2: return 32'(x) - 32'(y);
         3: return c + p;
         4: return c - p;
         default: return prev;
      endcase
   endfunction

   initial begin
      #1500000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic signed [31:0] exp;
      logic signed [15:0] vals [6];
      vals = '{16'sd0, 16'sd1, -16'sd1, 16'sd32767, -16'sd32768, 16'sd1234};
      rst = 1; en = 0; cfg_load = 0; cfg_op = 0; cfg_use_const = 0; cfg_coef = 0;
      a = 0; b = 0; chain_in = 0;
      tick(); tick();
      chk("R1 reset", 0);
      rst = 0; en = 1;
      a = 7; b = 9; tick();
      chk("R1 nop after reset", 0);

      // Sweep all ops against operand corners, b from port
      for (int op = 0; op < 8; op++) begin
         load(3'(op), 0, 16'h0);
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++) begin
               logic signed [31:0] prev;
               prev = res;
               a = vals[i]; b = vals[j];
               chain_in = 32'sh7FFF_FFF0 + 32'(i * 3 - j);
               exp = model(op, a, b, chain_in, prev);
               tick();
               case (op)
                  1, 2: chk("R3 add/sub", exp);
                  3, 4: chk("R4 R5 mac/msub wrap", exp);
                  0: chk("R9 nop hold", exp);
                  default: chk("R2 unknown code hold", exp);
               endcase
            end
      end

      // Constant operand: b must be ignored
      load(3'd3, 1, 16'hFFFD);
      for (int j = 0; j < 6; j++) begin
         a = 16'sd100; b = vals[j]; chain_in = 32'sd5;
         tick();
         chk("R6 constant operand", 32'sd5 - 32'sd300);
      end

      // Load does not disturb result; new op from next cycle
      load(3'd1, 0, 0);
      a = 10; b = 20; tick();
      chk("R3 add", 30);
      en = 0; a = 1; b = 1;
      load(3'd2, 0, 0);
      chk("R7 load leaves res", 30);
      chk("R8 hold while disabled", 30);
      tick();
      chk("R8 still held", 30);
      en = 1; a = 50; b = 8; tick();
      chk("R7 new op active", 42);
      en = 0; a = 3; b = 3; tick(); tick();
      chk("R8 disabled multi-cycle", 42);
      en = 1; tick();
      chk("R3 resumed sub", 0);

      // Reset mid-run clears config
      load(3'd1, 0, 0);
      a = 2; b = 3; tick();
      chk("R3 add", 5);
      rst = 1; tick(); rst = 0;
      chk("R1 reset clears", 0);
      a = 4; b = 4; tick();
      chk("R1 op is nop after reset", 0);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule